// File: doc/BRIEF.md
# Serial Write Output Buffer

This block is a transmit-only serial shifter with a deep bit store. Software fills the store four bits at a time. A start request then streams the stored bits out on a data pin, with a matching clock pin. Bits leave the low bit of each nibble first, and nibbles leave in the order they were written. The output clock idles low. Each bit spends one half period with the clock low and one half period with it high. The data line changes only when the clock falls, so a receiver samples on the rising edge.

The block has two send modes. In automatic mode a length value sets how many bits one transmission carries. In interactive mode the length is ignored and the stream runs for as long as the store holds bits. Software keeps the stream going by writing more nibbles, and a half-empty flag tells it when there is room to do so. A one-cycle interrupt pulse reports that transmission has drained the store. A busy flag covers the whole transmission.

Four bit rates can be chosen. They are fixed multiples of one base half period, which is set by a parameter from the system clock. With the base half period equal to one half of a 16 kHz bit, the four codes give 16 kHz, 8 kHz, 2 kHz and 1 kHz.

Top module: `swb_tx`

## Requirements
- R1: The store holds up to BUF_BITS bits as BUF_BITS/4 nibbles. The bits leave the low bit of each nibble first, and the nibbles leave in write order. A nibble write while all BUF_BITS/4 nibble slots are occupied is dropped.
- R2: The rate code latched at start sets the bit period to 2*HALF_BASE*M clock cycles, where M is 1, 2, 8 and 16 for codes 0, 1, 2 and 3 (16, 8, 2 and 1 kHz). Consecutive rising edges of `sclk` within one stream are exactly one bit period apart.
- R3: Each bit holds `sclk` low for HALF_BASE*M cycles and then high for HALF_BASE*M cycles. `sdata` stays constant while `sclk` is high.
- R4: With `mode`=0 (automatic), an accepted start sends exactly min(`len`, stored bits) bits. Any bits left over stay stored for a later start. A start with `len`=0 is ignored.
- R5: With `mode`=1 (interactive), `len` is ignored and bits are sent until the store is empty. A nibble accepted before or during the clock cycle in which the last stored bit leaves continues the stream without a gap.
- R6: `busy` rises the cycle after an accepted start. It stays high for exactly N bit periods, where N is the number of bits sent.
- R7: `irq_empty` pulses high for one cycle, together with the fall of `busy`, when sending has emptied the store. It does not pulse when an automatic transmission ends with bits left over.
- R8: `half_empty` is high exactly when the stored bit count is at most BUF_BITS/2.
- R9: A start is ignored while `busy` is high and while the store is empty. Changes on `rate`, `mode` and `len` during a transmission have no effect on it.
- R10: While `busy` is low, `sclk` and `sdata` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one nibble into the store |
| wr_data | input | 4 | Nibble to store, bit 0 sent first |
| start | input | 1 | Request to begin a transmission |
| mode | input | 1 | 0 automatic, 1 interactive |
| rate | input | 2 | Bit rate code: 0 16 kHz, 1 8 kHz, 2 2 kHz, 3 1 kHz |
| len | input | $clog2(BUF_BITS+1) | Bit count for automatic mode |
| sclk | output | 1 | Serial clock out, idles low |
| sdata | output | 1 | Serial data out, changes on the falling edge of sclk |
| busy | output | 1 | Transmission in progress |
| half_empty | output | 1 | At most half the store is occupied |
| irq_empty | output | 1 | One-cycle pulse when sending drains the store |

## Verification
Two events can land in the same clock cycle: a refill nibble write and the removal of the final stored bit at the end of a high phase. The bench counts the edges from the start request and places an interactive-mode write on exactly that edge. It then expects eight contiguous bits, evenly spaced, with a single interrupt at the very end. It repeats the case with the write one cycle late. There it expects the stream to stop after four bits with an interrupt, and the late nibble to stay stored so that a following automatic send delivers it.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // rate code -> multiple of the base half period (16k, 8k, 2k, 1k)
  function automatic int unsigned rate_mult(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/swb_nibble_fifo.sv
module swb_nibble_fifo #(
  parameter int BUF_BITS = 256,
  localparam int FW = $clog2(BUF_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_nib,
  input  logic          pop,
  output logic          head_bit,
  output logic [FW-1:0] fill_bits,
  output logic          wr_ok
);

  localparam int DEPTH = BUF_BITS / 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [3:0]    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] ncnt_q, ncnt_d;
  logic [1:0]    bpos_q, bpos_d;
  logic          full, pop_nib;

  always_comb begin
    full      = (ncnt_q == CW'(DEPTH));
    wr_ok     = wr_en && !full;
    pop_nib   = pop && (bpos_q == 2'd3);
    head_bit  = mem_q[rptr_q][bpos_q];
    fill_bits = FW'({ncnt_q, 2'b00}) - FW'(bpos_q);

    wptr_d = wr_ok   ? wptr_q + AW'(1) : wptr_q;
    rptr_d = pop_nib ? rptr_q + AW'(1) : rptr_q;
    bpos_d = pop     ? bpos_q + 2'd1   : bpos_q;
    ncnt_d = ncnt_q + CW'(wr_ok) - CW'(pop_nib);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wptr_q] <= wr_nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ncnt_q <= '0;
      bpos_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ncnt_q <= ncnt_d;
      bpos_q <= bpos_d;
    end
  end

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bits <= FW'(BUF_BITS));

  assert_full_write_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !pop) |=> (fill_bits == $past(fill_bits)));

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fill_bits != '0));

endmodule

// File: rtl/swb_halfper.sv
module swb_halfper #(
  parameter int HALF_BASE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       half_done
);

  localparam int MAXH = HALF_BASE * 16;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit     = CW'(HALF_BASE * swb_pkg::rate_mult(rate) - 1);
    half_done = run && (cnt_q == limit);
    cnt_d     = (!run || half_done) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

endmodule

// File: rtl/swb_tx.sv
module swb_tx #(
  parameter int BUF_BITS  = 256,
  parameter int HALF_BASE = 16,
  localparam int LW = $clog2(BUF_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_data,
  input  logic          start,
  input  logic          mode,
  input  logic [1:0]    rate,
  input  logic [LW-1:0] len,
  output logic          sclk,
  output logic          sdata,
  output logic          busy,
  output logic          half_empty,
  output logic          irq_empty
);

  import swb_pkg::*;

  phase_e        phase_q, phase_d;
  logic [1:0]    rate_q, rate_d;
  logic          mode_q, mode_d;
  logic [LW-1:0] left_q, left_d;
  logic          irq_q, irq_d;

  logic          pop, head_bit, wr_ok, half_done, start_ok;
  logic [LW-1:0] fill_bits, fill_after;

  swb_nibble_fifo #(.BUF_BITS(BUF_BITS)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_nib    (wr_data),
    .pop       (pop),
    .head_bit  (head_bit),
    .fill_bits (fill_bits),
    .wr_ok     (wr_ok)
  );

  swb_halfper #(.HALF_BASE(HALF_BASE)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (phase_q != PH_IDLE),
    .rate      (rate_q),
    .half_done (half_done)
  );

  always_comb begin
    phase_d = phase_q;
    rate_d  = rate_q;
    mode_d  = mode_q;
    left_d  = left_q;
    irq_d   = 1'b0;
    pop     = 1'b0;

    // bits still stored after this cycle's pop and write
    fill_after = fill_bits + (wr_ok ? LW'(4) : '0) - LW'(1);
    start_ok   = start && (fill_bits != '0) && (mode || (len != '0));

    case (phase_q)
      PH_IDLE: begin
        if (start_ok) begin
          phase_d = PH_LOW;
          rate_d  = rate;
          mode_d  = mode;
          left_d  = len;
        end
      end
      PH_LOW: begin
        if (half_done) phase_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (half_done) begin
          pop    = 1'b1;
          left_d = left_q - LW'(1);
          irq_d  = (fill_after == '0);
          if ((fill_after == '0) || (!mode_q && (left_q == LW'(1))))
            phase_d = PH_IDLE;
          else
            phase_d = PH_LOW;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rate_q  <= '0;
      mode_q  <= 1'b0;
      left_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rate_q  <= rate_d;
      mode_q  <= mode_d;
      left_q  <= left_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    busy       = (phase_q != PH_IDLE);
    sclk       = (phase_q == PH_HIGH);
    sdata      = busy && head_bit;
    half_empty = (fill_bits <= LW'(BUF_BITS / 2));
    irq_empty  = irq_q;
  end

  assert_data_held_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));

  assert_irq_when_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> ((fill_bits == '0) && !busy));

  assert_busy_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_auto_count_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> (left_q != '0));

endmodule

// File: tb/test_swb_tx.sv
module test_swb_tx;

  localparam int BUF_BITS  = 16;
  localparam int HALF_BASE = 2;
  localparam int LW        = $clog2(BUF_BITS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_data = '0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [1:0]    rate = '0;
  logic [LW-1:0] len = '0;
  logic          sclk, sdata, busy, half_empty, irq_empty;

  swb_tx #(.BUF_BITS(BUF_BITS), .HALF_BASE(HALF_BASE)) i_swb_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .start(start), .mode(mode), .rate(rate), .len(len),
    .sclk(sclk), .sdata(sdata), .busy(busy),
    .half_empty(half_empty), .irq_empty(irq_empty)
  );

  always #2.5 clk = ~clk;

  // output monitor, updates on falling clock edges only
  int   cyc = 0, nrise = 0, busy_cnt = 0, irq_cnt = 0, idle_bad = 0;
  bit   mon_bits [0:1023];
  int   mon_cyc  [0:1023];
  logic sclk_prev = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (sclk && !sclk_prev) begin
        mon_bits[nrise] = sdata;
        mon_cyc[nrise]  = cyc;
        nrise = nrise + 1;
      end
      sclk_prev = sclk;
      if (busy) busy_cnt = busy_cnt + 1;
      if (irq_empty) irq_cnt = irq_cnt + 1;
      if (!busy && (sdata || sclk)) idle_bad = idle_bad + 1;
    end
  end

  // expected store contents
  bit mb [0:1023];
  int mhead = 0, mtail = 0;

  int vectors = 0, miscmp = 0;
  int snap_r, snap_b, snap_i, cur_mult;

  function automatic int mult_of(input int r);
    return (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 8 : 16;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_nib(input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    if (mtail - mhead <= BUF_BITS - 4) begin
      for (int k = 0; k < 4; k++) mb[mtail + k] = d[k];
      mtail += 4;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start(input logic m, input int r, input int l);
    @(negedge clk);
    start = 1'b1; mode = m; rate = 2'(r); len = LW'(l);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic start_tx(input logic m, input int r, input int l);
    @(posedge clk);
    snap_r = nrise; snap_b = busy_cnt; snap_i = irq_cnt;
    cur_mult = mult_of(r);
    pulse_start(m, r, l);
  endtask

  task automatic finish_run(input int exp_n, input int exp_irq, input string req);
    int n, bad, gbad, per;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    @(posedge clk);
    per = 2 * HALF_BASE * cur_mult;
    n = nrise - snap_r;
    chk(n == exp_n, req, "bit count", n, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n; i++)
      if (mon_bits[snap_r + i] != mb[mhead + i]) bad++;
    chk(bad == 0, "R1", "bit order mismatches", bad, 0);
    gbad = 0;
    for (int i = 1; i < n; i++)
      if (mon_cyc[snap_r + i] - mon_cyc[snap_r + i - 1] != per) gbad++;
    chk(gbad == 0, "R2", "bit spacing errors", gbad, 0);
    chk(busy_cnt - snap_b == exp_n * per, "R6", "busy cycles", busy_cnt - snap_b, exp_n * per);
    chk(irq_cnt - snap_i == exp_irq, "R7", "irq pulses", irq_cnt - snap_i, exp_irq);
    mhead += exp_n;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  initial begin
    #1000000;
    vectors++; miscmp++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk(sclk == 1'b0, "R10", "sclk after reset", int'(sclk), 0);
    chk(sdata == 1'b0, "R10", "sdata after reset", int'(sdata), 0);
    chk(busy == 1'b0, "R6", "busy after reset", int'(busy), 0);
    chk(irq_empty == 1'b0, "R7", "irq after reset", int'(irq_empty), 0);
    chk(half_empty == 1'b1, "R8", "half_empty after reset", int'(half_empty), 1);

    // R2 R4: each rate, full automatic send
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) write_nib(4'((r * 5 + k * 3 + 1) & 15));
      @(negedge clk);
      chk(half_empty == 1'b0, "R8", "half_empty full store", int'(half_empty), 0);
      start_tx(1'b0, r, 16);
      finish_run(16, 1, "R4");
      chk(half_empty == 1'b1, "R8", "half_empty after drain", int'(half_empty), 1);
    end

    // R1 dropped write when full; R5 len ignored
    for (int k = 0; k < 5; k++) write_nib(4'(9 + k * 7));
    start_tx(1'b1, 1, 3);
    finish_run(16, 1, "R5");

    // R8 boundary, R4 partial send keeps leftover
    write_nib(4'hA); write_nib(4'h3);
    @(negedge clk);
    chk(half_empty == 1'b1, "R8", "half_empty at half", int'(half_empty), 1);
    write_nib(4'h6);
    @(negedge clk);
    chk(half_empty == 1'b0, "R8", "half_empty above half", int'(half_empty), 0);
    start_tx(1'b0, 0, 6);
    finish_run(6, 0, "R4");
    chk(half_empty == 1'b1, "R8", "half_empty with 6 left", int'(half_empty), 1);
    start_tx(1'b0, 2, 16);
    finish_run(6, 1, "R4");

    // R4 start with len 0 ignored
    write_nib(4'hD);
    start_tx(1'b0, 0, 0);
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R4", "busy after len0 start", int'(busy), 0);
    @(posedge clk);
    chk(nrise == snap_r, "R4", "bits after len0 start", nrise - snap_r, 0);
    start_tx(1'b1, 0, 0);
    finish_run(4, 1, "R5");

    // R9 start on empty store ignored
    start_tx(1'b0, 0, 5);
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after empty start", int'(busy), 0);

    // R5 refill in the same cycle as the last bit leaves
    write_nib(4'h5);
    start_tx(1'b1, 1, 0);
    repeat (8 * HALF_BASE * 2 - 2) @(negedge clk);
    write_nib(4'hC);
    finish_run(8, 1, "R5");

    // R5 refill one cycle late: stream stops, nibble kept
    write_nib(4'h9);
    start_tx(1'b1, 0, 0);
    repeat (8 * HALF_BASE - 1) @(negedge clk);
    write_nib(4'h2);
    finish_run(4, 1, "R5");
    start_tx(1'b0, 3, 4);
    finish_run(4, 1, "R4");

    // R9 start while busy ignored, rate held
    write_nib(4'hE); write_nib(4'h1);
    start_tx(1'b0, 0, 8);
    repeat (3) @(negedge clk);
    pulse_start(1'b1, 3, 1);
    finish_run(8, 1, "R9");

    // R5 refill mid-stream
    write_nib(4'h7);
    start_tx(1'b1, 2, 0);
    repeat (10) @(negedge clk);
    write_nib(4'hB); write_nib(4'h4);
    finish_run(12, 1, "R5");

    @(posedge clk);
    chk(idle_bad == 0, "R10", "idle cycles with activity", idle_bad, 0);

    summary();
  end

endmodule